// File: doc/BRIEF.md
# Codirectional Receive Decoder and Slip Buffer

This block takes the dual-rail, active-low line data of a 64 kbit/s codirectional interface and turns it into 8-bit bursts for a 2.048 MHz time-slot bus. A separate clock-recovery block supplies a tick per unit interval (four per line bit, both phases of the recovered 128 kHz clock) and marks the first unit interval of each bit. From these the decoder rebuilds the bit value and the polarity of each bit block. A block with the same polarity as the block before it is a violation, and a violation marks the last bit of an octet.

An octet framer counts bits from the last violation. When a violation fails to arrive, it keeps framing on the old count and tags the octet as unconfirmed. It raises an alarm after a run of such octets. Finished octets go into a two-slot ping-pong store that bridges the line rate and the local time-slot rate. At each rising edge of the selected time-slot strobe, the oldest unread octet is copied into an output shifter and played out first-received bit first. The burst uses one bit per 2.048 MHz enable. If no new octet is waiting, the last one is played again. If a new octet arrives while both slots hold unread data, the older one is overwritten.

Everything runs on one fast system clock. The line side and the PCM side are each gated by their own enable.

Top module: `codir_rx_deframer`

## Requirements
- R1: The line rails are active low: `line_pos_n`=0 is a positive mark and `line_neg_n`=0 a negative mark. A bit marked in both its first and second unit interval decodes as 1. A bit marked in its first interval and spaced in its second decodes as 0.
- R2: A violation is a bit block whose polarity equals that of the previous block. It closes an octet. Bits are played out in the order received: bit 0 of the output byte is the first bit on the line.
- R3: Once framed, the octet boundary is kept every 8 bits when violations are missing. With `keep_on_miss`=1 those octets are played out with their data intact.
- R4: With `keep_on_miss`=0, an octet that closed without its violation is played out as all ones.
- R5: `octet_alarm` is 1 from reset until the first violation. It rises once 8 consecutive octets close without a violation and not after 7. It falls with the next violation.
- R6: `force_ones`=1, sampled on each PCM enable, makes the next output bit 1.
- R7: `slot_pick`=1 selects `slot_a` and `slot_pick`=0 selects `slot_b`. When the selected strobe is low, `pcm_out` is 1.
- R8: On each `pcm_ce` with the selected strobe high, one of the 8 octet bits is output. `pcm_out` is registered, changes only in the cycle after a `pcm_ce`, and is 1 after the 8th bit until the strobe falls.
- R9: When an octet completes while both slots hold unread octets, the older unread octet is discarded. `slip_del` pulses for one cycle.
- R10: When a burst starts with no unread octet, the previously played octet is repeated. `slip_rep` is 1 from that burst's first bit until the strobe is seen low.
- R11: After reset, `pcm_out`=1, `octet_alarm`=1, and `slip_del`=`slip_rep`=0. The octet replayed before any data arrives is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_pos_n | input | 1 | Positive-mark rail, active low |
| line_neg_n | input | 1 | Negative-mark rail, active low |
| rec_tick | input | 1 | One-cycle pulse per unit interval from clock recovery |
| rec_first | input | 1 | With `rec_tick`, marks the first unit interval of a bit |
| pcm_ce | input | 1 | One-cycle enable per 2.048 MHz PCM bit |
| slot_a | input | 1 | Time-slot strobe A |
| slot_b | input | 1 | Time-slot strobe B |
| slot_pick | input | 1 | 1 selects strobe A, 0 selects strobe B |
| keep_on_miss | input | 1 | 1 keeps data of octets that closed without a violation |
| force_ones | input | 1 | 1 forces the PCM output to ones |
| pcm_out | output | 1 | Serial PCM output |
| octet_alarm | output | 1 | Octet-timing alarm |
| slip_del | output | 1 | One-cycle pulse when an unread octet is discarded |
| slip_rep | output | 1 | High during a burst that repeats the previous octet |

## Verification
The assertions check on every cycle that the output moves only after a PCM enable, and that it is 1 whenever the selected strobe is low or ones are forced. They also check that decoded bits and octets follow their inputs by one cycle, that the discard pulse follows an octet write, and that the alarm changes only on a bit with or without a violation. Only the bench scenarios can show the whole chain. These cover byte values through the decoder and framer, the exact boundary of 7 versus 8 missed violations, and the choice between repeat and discard when the frame period is longer or shorter than the line octet period. They also cover the replacement of unconfirmed octets by ones when keeping is off.

// File: rtl/codir_rx_pkg.sv
package codir_rx_pkg;

    // Line decoder state: fixed widths, shared by decoder and its checks
    typedef struct packed {
        logic [1:0] ui_idx;     // unit interval expected on next tick
        logic       mark0;      // a mark was seen in the first interval
        logic       pol0;       // polarity of the first interval (1 = positive)
        logic       last_pol;   // polarity of the previous bit block
        logic       have_pol;   // last_pol is valid
        logic       bit_vld;
        logic       bit_val;
        logic       viol;
    } dec_state_t;

    // Source chosen for a PCM burst
    typedef enum logic {
        RD_REPEAT = 1'b0,
        RD_SLOT   = 1'b1
    } rd_src_e;

endpackage

// File: rtl/codir_line_decode.sv
module codir_line_decode
    import codir_rx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pos_n,
    input  logic neg_n,
    input  logic tick,
    input  logic first,
    output logic bit_vld,
    output logic bit_val,
    output logic viol
);

    dec_state_t st_d, st_q;
    logic       mark_w;
    logic       pos_w;

    assign mark_w = !pos_n || !neg_n;
    assign pos_w  = !pos_n;

    always_comb begin
        st_d         = st_q;
        st_d.bit_vld = 1'b0;
        st_d.viol    = 1'b0;
        if (tick) begin
            if (first) begin
                st_d.ui_idx = 2'd1;
                st_d.mark0  = mark_w;
                st_d.pol0   = pos_w;
            end else begin
                st_d.ui_idx = st_q.ui_idx + 2'd1;
                if (st_q.ui_idx == 2'd1 && st_q.mark0) begin
                    st_d.bit_vld  = 1'b1;
                    st_d.bit_val  = mark_w;
                    st_d.viol     = st_q.have_pol && (st_q.pol0 == st_q.last_pol);
                    st_d.last_pol = st_q.pol0;
                    st_d.have_pol = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bit_vld = st_q.bit_vld;
    assign bit_val = st_q.bit_val;
    assign viol    = st_q.viol;

    // R1: a decoded bit follows a non-first unit-interval tick
    assert_bit_after_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
        bit_vld |-> $past(tick && !first));

    // R2: a violation is only flagged together with a decoded bit
    assert_viol_with_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        viol |-> bit_vld);

endmodule

// File: rtl/codir_octet_frame.sv
module codir_octet_frame #(
    parameter int OCT_W      = 8,
    parameter int MISS_LIMIT = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_vld,
    input  logic             bit_val,
    input  logic             viol,
    output logic             oct_vld,
    output logic [OCT_W-1:0] oct_data,
    output logic             oct_miss,
    output logic             alarm
);

    localparam int CW = $clog2(OCT_W);
    localparam int MW = $clog2(MISS_LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(OCT_W - 1);
    localparam logic [MW-1:0] LIM  = MW'(MISS_LIMIT);

    typedef struct packed {
        logic [OCT_W-1:0] sr;
        logic [CW-1:0]    cnt;
        logic             locked;
        logic [MW-1:0]    misses;
        logic             vld;
        logic [OCT_W-1:0] data;
        logic             miss;
    } frm_t;

    frm_t fr_d, fr_q;
    logic [OCT_W-1:0] sr_next;

    always_comb begin
        fr_d     = fr_q;
        fr_d.vld = 1'b0;
        sr_next  = {bit_val, fr_q.sr[OCT_W-1:1]};
        if (bit_vld) begin
            fr_d.sr = sr_next;
            if (viol) begin
                fr_d.vld    = 1'b1;
                fr_d.data   = sr_next;
                fr_d.miss   = 1'b0;
                fr_d.cnt    = '0;
                fr_d.locked = 1'b1;
                fr_d.misses = '0;
            end else if (fr_q.locked && fr_q.cnt == LAST) begin
                fr_d.vld    = 1'b1;
                fr_d.data   = sr_next;
                fr_d.miss   = 1'b1;
                fr_d.cnt    = '0;
                fr_d.misses = (fr_q.misses == LIM) ? LIM : fr_q.misses + 1'b1;
            end else begin
                fr_d.cnt = fr_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fr_q        <= '0;
            fr_q.misses <= LIM;
        end else begin
            fr_q <= fr_d;
        end
    end

    assign oct_vld  = fr_q.vld;
    assign oct_data = fr_q.data;
    assign oct_miss = fr_q.miss;
    assign alarm    = (fr_q.misses == LIM);

    // R2: octets are only produced from a decoded bit
    assert_octet_from_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        oct_vld |-> $past(bit_vld));

    // R5: alarm clears only on a received violation
    assert_alarm_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(alarm) |-> $past(bit_vld && viol));

    // R5: alarm sets only on a bit without a violation
    assert_alarm_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm) |-> $past(bit_vld && !viol));

endmodule

// File: rtl/codir_slip_buf.sv
module codir_slip_buf
    import codir_rx_pkg::*;
#(
    parameter int OCT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             oct_vld,
    input  logic [OCT_W-1:0] oct_data,
    input  logic             oct_miss,
    input  logic             pcm_ce,
    input  logic             slot,
    input  logic             keep,
    input  logic             force_ones,
    output logic             pcm_out,
    output logic             del_flag,
    output logic             rep_flag
);

    localparam int BW = $clog2(OCT_W + 1);
    localparam logic [BW-1:0] NBITS = BW'(OCT_W);

    typedef struct packed {
        logic [1:0][OCT_W-1:0] slot_data;
        logic [1:0]            slot_miss;
        logic [1:0]            fresh;
        logic                  wptr;
        logic [OCT_W-1:0]      last_data;
        logic                  last_miss;
        logic [OCT_W-1:0]      sh;
        logic                  cur_miss;
        logic [BW-1:0]         nbit;
        logic                  slot_prev;
        logic                  pcm;
        logic                  del;
        logic                  rep;
    } sb_t;

    sb_t sb_d, sb_q;
    rd_src_e          src;
    logic             sidx;
    logic [OCT_W-1:0] pick;
    logic             pick_miss;
    logic [1:0]       fresh_rd;

    always_comb begin
        sb_d     = sb_q;
        sb_d.del = 1'b0;
        fresh_rd = sb_q.fresh;

        // oldest unread slot first, otherwise repeat
        if (sb_q.fresh[sb_q.wptr]) begin
            src  = RD_SLOT;
            sidx = sb_q.wptr;
        end else if (sb_q.fresh[!sb_q.wptr]) begin
            src  = RD_SLOT;
            sidx = !sb_q.wptr;
        end else begin
            src  = RD_REPEAT;
            sidx = sb_q.wptr;
        end
        pick      = (src == RD_SLOT) ? sb_q.slot_data[sidx] : sb_q.last_data;
        pick_miss = (src == RD_SLOT) ? sb_q.slot_miss[sidx] : sb_q.last_miss;

        if (pcm_ce) begin
            sb_d.slot_prev = slot;
            if (slot && !sb_q.slot_prev) begin
                if (src == RD_SLOT) fresh_rd[sidx] = 1'b0;
                sb_d.last_data = pick;
                sb_d.last_miss = pick_miss;
                sb_d.cur_miss  = pick_miss;
                sb_d.rep       = (src == RD_REPEAT);
                sb_d.sh        = pick >> 1;
                sb_d.nbit      = BW'(1);
                sb_d.pcm       = (force_ones || (pick_miss && !keep)) ? 1'b1 : pick[0];
            end else if (slot && sb_q.nbit < NBITS) begin
                sb_d.sh   = sb_q.sh >> 1;
                sb_d.nbit = sb_q.nbit + 1'b1;
                sb_d.pcm  = (force_ones || (sb_q.cur_miss && !keep)) ? 1'b1 : sb_q.sh[0];
            end else begin
                sb_d.pcm = 1'b1;
                if (!slot) sb_d.rep = 1'b0;
            end
        end

        sb_d.fresh = fresh_rd;
        if (oct_vld) begin
            sb_d.slot_data[sb_q.wptr] = oct_data;
            sb_d.slot_miss[sb_q.wptr] = oct_miss;
            sb_d.del                  = fresh_rd[sb_q.wptr];
            sb_d.fresh[sb_q.wptr]     = 1'b1;
            sb_d.wptr                 = !sb_q.wptr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sb_q           <= '0;
            sb_q.pcm       <= 1'b1;
            sb_q.last_data <= '1;
        end else begin
            sb_q <= sb_d;
        end
    end

    assign pcm_out  = sb_q.pcm;
    assign del_flag = sb_q.del;
    assign rep_flag = sb_q.rep;

    // R7: outside the selected window the output idles high
    assert_idle_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pcm_ce && !slot) |=> pcm_out);

    // R8: output moves only after a PCM enable (glitch-free, registered)
    assert_pcm_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !pcm_ce |=> $stable(pcm_out));

    // R6: forced ones reach the output on the next enable
    assert_force_ones_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pcm_ce && force_ones) |=> pcm_out);

    // R9: a discard follows an octet write
    assert_del_after_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        del_flag |-> $past(oct_vld));

    // R10: the repeat flag only changes on a PCM enable
    assert_rep_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !pcm_ce |=> $stable(rep_flag));

endmodule

// File: rtl/codir_rx_deframer.sv
module codir_rx_deframer #(
    parameter int OCT_W      = 8,
    parameter int MISS_LIMIT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_pos_n,
    input  logic line_neg_n,
    input  logic rec_tick,
    input  logic rec_first,
    input  logic pcm_ce,
    input  logic slot_a,
    input  logic slot_b,
    input  logic slot_pick,
    input  logic keep_on_miss,
    input  logic force_ones,
    output logic pcm_out,
    output logic octet_alarm,
    output logic slip_del,
    output logic slip_rep
);

    logic             bit_vld;
    logic             bit_val;
    logic             viol;
    logic             oct_vld;
    logic [OCT_W-1:0] oct_data;
    logic             oct_miss;
    logic             slot_sel;

    assign slot_sel = slot_pick ? slot_a : slot_b;

    codir_line_decode u_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .pos_n   (line_pos_n),
        .neg_n   (line_neg_n),
        .tick    (rec_tick),
        .first   (rec_first),
        .bit_vld (bit_vld),
        .bit_val (bit_val),
        .viol    (viol)
    );

    codir_octet_frame #(
        .OCT_W      (OCT_W),
        .MISS_LIMIT (MISS_LIMIT)
    ) u_frm (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_vld  (bit_vld),
        .bit_val  (bit_val),
        .viol     (viol),
        .oct_vld  (oct_vld),
        .oct_data (oct_data),
        .oct_miss (oct_miss),
        .alarm    (octet_alarm)
    );

    codir_slip_buf #(
        .OCT_W (OCT_W)
    ) u_buf (
        .clk        (clk),
        .rst_n      (rst_n),
        .oct_vld    (oct_vld),
        .oct_data   (oct_data),
        .oct_miss   (oct_miss),
        .pcm_ce     (pcm_ce),
        .slot       (slot_sel),
        .keep       (keep_on_miss),
        .force_ones (force_ones),
        .pcm_out    (pcm_out),
        .del_flag   (slip_del),
        .rep_flag   (slip_rep)
    );

endmodule

// File: tb/tb_codir_rx_deframer.sv
module tb_codir_rx_deframer;

    logic clk = 1'b0;
    logic rst_n;
    logic line_pos_n, line_neg_n, rec_tick, rec_first;
    logic pcm_ce, slot_a, slot_b, slot_pick, keep_on_miss, force_ones;
    logic pcm_out, octet_alarm, slip_del, slip_rep;

    always #4 clk = ~clk;   // 125 MHz

    codir_rx_deframer dut (.*);

    int errors = 0;
    int checks = 0;
    int sent   = 0;
    int dels   = 0;
    int reps   = 0;
    int cfg_frame = 256;
    bit cfg_sel   = 1'b1;
    bit cfg_keep  = 1'b1;
    bit cfg_blank = 1'b0;
    bit cfg_viol  = 1'b1;
    bit run       = 1'b0;
    logic [8:0] expq[$];   // {miss, data}

    task automatic check(input bit ok, input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s got=%h exp=%h at %0t", req, got, exp, $time);
        end
    endtask

    task automatic wait_oct(input int n);
        int target;
        target = sent + n;
        while (sent < target) @(negedge clk);
    endtask

    // line driver: pushes each octet before its last bit goes out
    initial begin
        logic lastp;
        lastp = 1'b0;
        line_pos_n = 1'b1; line_neg_n = 1'b1; rec_tick = 1'b0; rec_first = 1'b0;
        wait (run);
        forever begin
            logic [7:0] data;
            data = 8'h35 + 8'(sent * 75);
            for (int i = 0; i < 8; i++) begin
                logic v, p, b;
                b = data[i];
                v = 1'b0;
                if (i == 7) begin
                    v = cfg_viol;
                    expq.push_back({!v, data});
                end
                p = v ? lastp : !lastp;
                lastp = p;
                for (int u = 0; u < 4; u++) begin
                    logic mark;
                    mark = (u == 0) || (u == 1 && b) || (u == 2 && !b);
                    @(negedge clk);
                    line_pos_n = !(mark && p);
                    line_neg_n = !(mark && !p);
                    rec_tick   = 1'b1;
                    rec_first  = (u == 0);
                    @(negedge clk);
                    rec_tick  = 1'b0;
                    rec_first = 1'b0;
                    repeat (6) @(negedge clk);
                end
            end
            sent++;
        end
    end

    // PCM frame driver: window A at cycle 0, window B at cycle 80
    initial begin
        pcm_ce = 1'b0; slot_a = 1'b0; slot_b = 1'b0;
        slot_pick = 1'b1; keep_on_miss = 1'b1; force_ones = 1'b0;
        wait (run);
        forever begin
            int fr;
            fr = cfg_frame;
            for (int c = 0; c < fr; c++) begin
                @(negedge clk);
                if (c == 0) begin
                    slot_pick    = cfg_sel;
                    keep_on_miss = cfg_keep;
                    force_ones   = cfg_blank;
                end
                pcm_ce = (c % 2 == 0);
                slot_a = (c < 16);
                slot_b = (c >= 80 && c < 96);
            end
        end
    end

    // monitor / scoreboard
    initial begin
        int mbit;
        logic [7:0] acc, expv, last_d;
        logic last_m, ce, sel_s, oth_s, kp, bl, rep_now;
        logic [8:0] e;
        string tag;
        mbit = 0; last_d = 8'hFF; last_m = 1'b0; acc = '0; expv = '0;
        rep_now = 1'b0; e = '0; tag = "R2";
        wait (run);
        forever begin
            @(posedge clk);
            ce    = pcm_ce;
            sel_s = slot_pick ? slot_a : slot_b;
            oth_s = slot_pick ? slot_b : slot_a;
            kp    = keep_on_miss;
            bl    = force_ones;
            @(negedge clk);
            if (ce && sel_s && mbit < 8) begin
                if (mbit == 0) begin
                    rep_now = slip_rep;
                    if (rep_now) begin
                        reps++;
                        e = {last_m, last_d};
                    end else if (expq.size() == 0) begin
                        check(1'b0, "R10 fresh burst with nothing sent", 8'h00, 8'h01);
                        e = {last_m, last_d};
                    end else begin
                        e = expq.pop_front();
                    end
                    last_d = e[7:0];
                    last_m = e[8];
                    expv = (bl || (e[8] && !kp)) ? 8'hFF : e[7:0];
                    if (bl)              tag = "R6 forced ones";
                    else if (e[8] && !kp) tag = "R4 unconfirmed blanked";
                    else if (rep_now)    tag = "R10 repeated octet";
                    else if (e[8])       tag = "R3 flywheel octet";
                    else                 tag = "R1/R2 decoded octet";
                end
                acc[mbit] = pcm_out;
                mbit++;
                if (mbit == 8) check(acc == expv, tag, acc, expv);   // R8 burst of 8
            end else if (ce && !sel_s) begin
                mbit = 0;
                if (oth_s) check(pcm_out == 1'b1, "R7 unselected window", {7'd0, pcm_out}, 8'h01);
            end
            if (slip_del) begin
                dels++;
                if (expq.size() == 0) check(1'b0, "R9 discard with empty queue", 8'h00, 8'h01);
                else void'(expq.pop_front());
            end
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int d0, r0;
        rst_n = 1'b0;
        repeat (10) @(negedge clk);
        check(pcm_out == 1'b1,     "R11 pcm_out reset",  {7'd0, pcm_out}, 8'h01);
        check(octet_alarm == 1'b1, "R11 alarm reset",    {7'd0, octet_alarm}, 8'h01);
        check(slip_del == 1'b0,    "R11 slip_del reset", {7'd0, slip_del}, 8'h00);
        check(slip_rep == 1'b0,    "R11 slip_rep reset", {7'd0, slip_rep}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        run = 1'b1;

        wait_oct(12);
        check(octet_alarm == 1'b0, "R5 alarm cleared by violation", {7'd0, octet_alarm}, 8'h00);

        cfg_sel = 1'b0;           // R7: strobe B
        wait_oct(6);
        cfg_sel = 1'b1;

        d0 = dels;
        cfg_frame = 300;          // R9: slow readout
        wait_oct(20);
        check(dels > d0, "R9 discards on slow readout", 8'(dels - d0), 8'h01);

        r0 = reps;
        cfg_frame = 220;          // R10: fast readout
        wait_oct(20);
        check(reps > r0, "R10 repeats on fast readout", 8'(reps - r0), 8'h01);
        cfg_frame = 256;
        wait_oct(4);

        cfg_viol = 1'b0;          // R3 / R5 flywheel
        wait_oct(7);
        check(octet_alarm == 1'b0, "R5 no alarm after 7 misses", {7'd0, octet_alarm}, 8'h00);
        wait_oct(1);
        check(octet_alarm == 1'b1, "R5 alarm after 8 misses", {7'd0, octet_alarm}, 8'h01);
        cfg_keep = 1'b0;          // R4
        wait_oct(3);
        cfg_viol = 1'b1;
        wait_oct(1);
        check(octet_alarm == 1'b0, "R5 alarm clears on violation", {7'd0, octet_alarm}, 8'h00);
        wait_oct(2);
        cfg_keep = 1'b1;

        cfg_blank = 1'b1;         // R6
        wait_oct(4);
        cfg_blank = 1'b0;
        wait_oct(4);
        repeat (600) @(negedge clk);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule